// File: doc/BRIEF.md
# 6502 Bus Glue Address Decoder

This block is the purely combinational glue logic for a 6502-style processor bus. It takes the upper twelve address lines (A15..A4), the read/write line and the phase-2 clock. From these it produces active-low strobes and selects for memory and for I/O devices.

Memory reads and writes are timed by a read strobe and a write strobe. Both are gated by the phase-2 clock, not by the chip selects. This lets the memories use their faster output-enable path.

All 65xx-family peripherals share one select that covers the I/O page at $80xx. It asserts only when exactly one of A7..A4 is high. That address bit itself drives the positive chip-select input of the matching device. As a result, at most one peripheral is ever enabled.

Two latch enables, qualified by the phase-2 clock, sit in gaps of that pattern. An expansion select covers the top quarter of the page. The first sixteen bytes of the page select nothing, so a top-of-memory probe at $8000 has no side effects. RAM and ROM chip selects complete the map.

Top module: `bus_glue_decoder`

## Requirements
- R1: `rd_n` is 0 exactly when `rw` = 1 and `phi2` = 1, independent of address.
- R2: `wr_n` is 0 exactly when `rw` = 0 and `phi2` = 1, independent of address; `rd_n` and `wr_n` are never both 0.
- R3: `per65_cs_n` is 0 exactly when A15..A8 = $80 and exactly one of A7..A4 is 1 ($801x, $802x, $804x, $808x). It is independent of `rw` and `phi2`.
- R4: `latch1_le_n` is 0 exactly when the address is $805x and `phi2` = 1.
- R5: `latch2_le_n` is 0 exactly when the address is $806x and `phi2` = 1.
- R6: `expn_cs_n` is 0 for every address $80C0–$80FF (A7 = A6 = 1 in page $80), whatever the values of `phi2` and `rw`.
- R7: Addresses $8000–$800F leave all four I/O outputs at 1, and so does every address outside page $80.
- R8: At most one of the four I/O outputs is 0 at any time. At most one peripheral is enabled, where peripheral k counts as enabled when `per65_cs_n` = 0 and A(4+k) = 1.
- R9: `ram_cs_n` is 0 exactly when A15 = 0.
- R10: `rom_cs_n` is 0 exactly when A15 = A14 = 1 ($C000–$FFFF). Neither memory select is 0 anywhere in page $80.
- R11: No output has state: each one is fully determined by the present inputs, and it settles within the same cycle in which those inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_hi | input | 12 | Address lines A15..A4 (bit 11 is A15) |
| rw | input | 1 | 1 = read, 0 = write |
| phi2 | input | 1 | Phase-2 bus clock |
| rd_n | output | 1 | Memory output enable, active low |
| wr_n | output | 1 | Memory write enable, active low |
| ram_cs_n | output | 1 | RAM chip select, active low |
| rom_cs_n | output | 1 | ROM chip select, active low |
| per65_cs_n | output | 1 | Shared 65xx peripheral select, active low |
| latch1_le_n | output | 1 | First addressable latch enable, active low |
| latch2_le_n | output | 1 | Second addressable latch enable, active low |
| expn_cs_n | output | 1 | Expansion window select, active low |

## Verification
The block holds no registers, so every output is due zero cycles after its inputs change. The bench drives each input set just after a falling edge of its timing clock. It samples a few nanoseconds later, inside the same cycle, and never near a rising edge. Because no result waits on a clock, an input set and its check always share one cycle. This holds for the vector table, the full sweep of page $80 over both `rw` values and both `phi2` phases, and the sweep of the whole address space.

// File: rtl/bus_glue_pkg.sv
package bus_glue_pkg;
  // Address lines carried into the decoder: A15..A4.
  localparam int ADDR_HI_W = 12;
  // Low nibble of the carried lines is A7..A4; the rest form the page.
  localparam int NIB_W     = 4;
  localparam int PAGE_W    = ADDR_HI_W - NIB_W;

  // Active-high internal view of the I/O selects.
  typedef struct packed {
    logic per65;
    logic latch1;
    logic latch2;
    logic expn;
  } io_sel_t;

  localparam int IO_SEL_N = $bits(io_sel_t);
endpackage

// File: rtl/glue_strobe_gen.sv
module glue_strobe_gen (
  input  logic rw,
  input  logic phi2,
  output logic rd_n,
  output logic wr_n
);
  always_comb begin
    rd_n = ~(rw & phi2);
    wr_n = ~(~rw & phi2);
  end

  // Checks R2: the two strobes are mutually exclusive.
  always_comb begin
    assert_strobe_excl_R2: assert (rd_n | wr_n)
      else $error("read and write strobes both active");
    assert_strobe_phi2_R1: assert (phi2 | (rd_n & wr_n))
      else $error("strobe active while phi2 low");
  end
endmodule

// File: rtl/glue_io_decode.sv
module glue_io_decode
  import bus_glue_pkg::*;
#(
  parameter logic [PAGE_W-1:0] IO_PAGE = 8'h80,
  parameter logic [NIB_W-1:0]  LE1_NIB = 4'h5,
  parameter logic [NIB_W-1:0]  LE2_NIB = 4'h6,
  // Number of top nibble bits that must all be 1 for the expansion window.
  parameter int                EXP_TOP = 2
) (
  input  logic [ADDR_HI_W-1:0] a_hi,
  input  logic                 phi2,
  output io_sel_t              sel
);
  logic             page_hit;
  logic [NIB_W-1:0] nib;
  logic             nib_single;
  logic [IO_SEL_N-1:0] sel_vec;

  assign nib      = a_hi[NIB_W-1:0];
  assign page_hit = (a_hi[ADDR_HI_W-1:NIB_W] == IO_PAGE);

  // One-hot detect of the nibble: exactly one line set.
  always_comb begin
    int unsigned ones;
    ones = 0;
    for (int i = 0; i < NIB_W; i++) ones += int'(nib[i]);
    nib_single = (ones == 1);
  end

  always_comb begin
    sel.per65  = page_hit & nib_single;
    sel.latch1 = page_hit & (nib == LE1_NIB) & phi2;
    sel.latch2 = page_hit & (nib == LE2_NIB) & phi2;
    sel.expn   = page_hit & (&nib[NIB_W-1:NIB_W-EXP_TOP]);
  end

  assign sel_vec = sel;

  always_comb begin
    // R8: never two I/O selects together.
    assert_io_onehot_R8: assert ($countones(sel_vec) <= 1)
      else $error("more than one I/O select active");
    // R7: guard gap at the bottom of the I/O page.
    assert_guard_gap_R7: assert (!(page_hit && nib == '0) || sel_vec == '0)
      else $error("I/O select in guard gap");
    // R4/R5: latch enables only during phi2 high.
    assert_latch_phi2_R4: assert (phi2 || !(sel.latch1 || sel.latch2))
      else $error("latch enable while phi2 low");
  end
endmodule

// File: rtl/glue_mem_decode.sv
module glue_mem_decode #(
  // Upper address bits that must all be 1 for the ROM window.
  parameter int ROM_BITS = 2
) (
  input  logic [ROM_BITS-1:0] a_top,
  output logic                ram_cs_n,
  output logic                rom_cs_n
);
  always_comb begin
    ram_cs_n = a_top[ROM_BITS-1];
    rom_cs_n = ~(&a_top);
  end

  always_comb begin
    assert_mem_excl_R10: assert (ram_cs_n | rom_cs_n)
      else $error("RAM and ROM selected together");
  end
endmodule

// File: rtl/bus_glue_decoder.sv
module bus_glue_decoder
  import bus_glue_pkg::*;
#(
  parameter logic [PAGE_W-1:0] IO_PAGE  = 8'h80,
  parameter logic [NIB_W-1:0]  LE1_NIB  = 4'h5,
  parameter logic [NIB_W-1:0]  LE2_NIB  = 4'h6,
  parameter int                ROM_BITS = 2
) (
  input  logic [ADDR_HI_W-1:0] a_hi,
  input  logic                 rw,
  input  logic                 phi2,
  output logic                 rd_n,
  output logic                 wr_n,
  output logic                 ram_cs_n,
  output logic                 rom_cs_n,
  output logic                 per65_cs_n,
  output logic                 latch1_le_n,
  output logic                 latch2_le_n,
  output logic                 expn_cs_n
);
  io_sel_t io_sel;

  glue_strobe_gen u_strobe (
    .rw   (rw),
    .phi2 (phi2),
    .rd_n (rd_n),
    .wr_n (wr_n)
  );

  glue_io_decode #(
    .IO_PAGE (IO_PAGE),
    .LE1_NIB (LE1_NIB),
    .LE2_NIB (LE2_NIB),
    .EXP_TOP (2)
  ) u_io (
    .a_hi (a_hi),
    .phi2 (phi2),
    .sel  (io_sel)
  );

  glue_mem_decode #(
    .ROM_BITS (ROM_BITS)
  ) u_mem (
    .a_top    (a_hi[ADDR_HI_W-1 -: ROM_BITS]),
    .ram_cs_n (ram_cs_n),
    .rom_cs_n (rom_cs_n)
  );

  always_comb begin
    per65_cs_n  = ~io_sel.per65;
    latch1_le_n = ~io_sel.latch1;
    latch2_le_n = ~io_sel.latch2;
    expn_cs_n   = ~io_sel.expn;
  end

  // R10: memory selects stay off inside the I/O page.
  always_comb begin
    assert_io_mem_apart_R10: assert (
        (per65_cs_n & latch1_le_n & latch2_le_n & expn_cs_n) |
        (ram_cs_n & rom_cs_n))
      else $error("memory select overlaps I/O select");
  end
endmodule

// File: tb/tb_bus_glue_decoder.sv
module tb_bus_glue_decoder;
  logic        clk = 1'b0;
  logic [11:0] a_hi = '0;
  logic        rw = 1'b1, phi2 = 1'b0;
  logic rd_n, wr_n, ram_cs_n, rom_cs_n, per65_cs_n, latch1_le_n, latch2_le_n, expn_cs_n;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bus_glue_decoder dut (
    .a_hi(a_hi), .rw(rw), .phi2(phi2),
    .rd_n(rd_n), .wr_n(wr_n), .ram_cs_n(ram_cs_n), .rom_cs_n(rom_cs_n),
    .per65_cs_n(per65_cs_n), .latch1_le_n(latch1_le_n),
    .latch2_le_n(latch2_le_n), .expn_cs_n(expn_cs_n)
  );

  // Vector: {a_hi, rw, phi2, expected {rd,wr,ram,rom,per65,le1,le2,expn}}
  localparam int NV = 17;
  localparam logic [21:0] VEC [NV] = '{
    {12'h000, 1'b1, 1'b1, 8'b0101_1111},
    {12'h800, 1'b0, 1'b1, 8'b1011_1111},
    {12'h801, 1'b1, 1'b0, 8'b1111_0111},
    {12'h802, 1'b0, 1'b1, 8'b1011_0111},
    {12'h804, 1'b1, 1'b1, 8'b0111_0111},
    {12'h808, 1'b1, 1'b0, 8'b1111_0111},
    {12'h803, 1'b1, 1'b1, 8'b0111_1111},
    {12'h805, 1'b0, 1'b1, 8'b1011_1011},
    {12'h805, 1'b0, 1'b0, 8'b1111_1111},
    {12'h806, 1'b1, 1'b1, 8'b0111_1101},
    {12'h80C, 1'b1, 1'b0, 8'b1111_1110},
    {12'h80F, 1'b0, 1'b1, 8'b1011_1110},
    {12'hFFF, 1'b1, 1'b1, 8'b0110_1111},
    {12'hC00, 1'b1, 1'b0, 8'b1110_1111},
    {12'h7FF, 1'b0, 1'b1, 8'b1001_1111},
    {12'h901, 1'b1, 1'b1, 8'b0111_1111},
    {12'h001, 1'b1, 1'b0, 8'b1101_1111}
  };

  function automatic logic [7:0] outs();
    return {rd_n, wr_n, ram_cs_n, rom_cs_n, per65_cs_n, latch1_le_n, latch2_le_n, expn_cs_n};
  endfunction

  // Expected outputs from the address map, as byte address ranges.
  function automatic logic [7:0] expect_of(input logic [11:0] a, input logic r, input logic p);
    int unsigned adr;
    logic in_page, one_dev;
    logic [3:0] n;
    adr = {16'h0, a, 4'h0};
    in_page = (adr >= 32'h8000) && (adr <= 32'h80FF);
    n = a[3:0];
    one_dev = (n == 4'h1) || (n == 4'h2) || (n == 4'h4) || (n == 4'h8);
    return {
      !(r && p),
      !(!r && p),
      !(adr < 32'h8000),
      !(adr >= 32'hC000),
      !(in_page && one_dev),
      !(in_page && adr >= 32'h8050 && adr <= 32'h805F && p),
      !(in_page && adr >= 32'h8060 && adr <= 32'h806F && p),
      !(in_page && adr >= 32'h80C0)
    };
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s a=%h rw=%b phi2=%b actual=%b expected=%b", req, a_hi, rw, phi2, got, exp);
    end
  endtask

  task automatic apply(input logic [11:0] a, input logic r, input logic p);
    @(negedge clk);
    a_hi = a; rw = r; phi2 = p;
    #3;
  endtask

  initial begin
    // R11: idle inputs, checked before any clock edge is relied on.
    #3;
    check("R11 idle state", outs(), 8'b1101_1111);

    // Table walk (R1 R2 R3 R4 R5 R6 R7 R9 R10)
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][21:10], VEC[i][9], VEC[i][8]);
      check($sformatf("vector %0d R1/R2/R3/R4/R5/R6/R9/R10", i), outs(), VEC[i][7:0]);
    end

    // Page $80 sweep over rw and phi2: R3 R4 R5 R6 R7 R8
    for (int n = 0; n < 256; n++) begin
      for (int k = 0; k < 4; k++) begin
        logic [3:0] dev;
        apply({8'h80, n[7:4] == 0 ? n[3:0] : n[3:0]}, k[0], k[1]);
        check("R3 R4 R5 R6 R7 page sweep", outs(), expect_of(a_hi, rw, phi2));
        check("R8 one I/O select", {7'd0, $countones({per65_cs_n, latch1_le_n, latch2_le_n, expn_cs_n}) >= 3},
              8'd1);
        dev = per65_cs_n ? 4'b0000 : a_hi[3:0];
        check("R8 one device", {7'd0, $countones(dev) <= 1}, 8'd1);
      end
    end

    // R7: $8000 probe under every strobe phase leaves I/O idle.
    for (int k = 0; k < 4; k++) begin
      apply(12'h800, k[0], k[1]);
      check("R7 top-of-RAM probe", {4'h0, per65_cs_n, latch1_le_n, latch2_le_n, expn_cs_n}, 8'h0F);
    end

    // Whole address space with both phases: R1 R2 R9 R10 R7 and R11 settling.
    for (int a = 0; a < 4096; a++) begin
      apply(a[11:0], a[0], a[1]);
      check("R1 R2 R7 R9 R10 R11 full sweep", outs(), expect_of(a_hi, rw, phi2));
    end

    // R6 boundaries: $80B0 outside, $80C0 inside, regardless of phi2.
    apply(12'h80B, 1'b1, 1'b0);
    check("R6 below window", {7'd0, expn_cs_n}, 8'd1);
    apply(12'h80C, 1'b0, 1'b0);
    check("R6 window start phi2 low", {7'd0, expn_cs_n}, 8'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule